// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter

A controller running with external memory puts the low half of its address and its data on one set of shared pins, one after the other. This block takes those shared pins apart. While the address strobe is high, the pins carry the low address byte. When the strobe falls, the block stores that byte in a register. The register then drives a steady low-address output for the rest of the bus cycle, while the same pins go on to carry data.

The data phase of a bus cycle is the time the E phase input is high. On a write cycle (read/write low), the block takes the byte on the shared pins at the end of the data phase. It presents that byte on a data output and marks it with a one-clock valid pulse. On a read cycle, the block takes no data from the pins.

All inputs are sampled synchronously on the system clock through a two-stage sample register. Edges are detected on the sampled copies.

Top module: `adbus_demux`

## Requirements
- R1: A clock edge with `rst_n` low clears `addr_lo` and `wr_data` to 0 and drives `wr_valid` low.
- R2: Take the first clock edge that samples `addr_strobe` low after an edge that sampled it high. At the next edge, `addr_lo` loads the `ad_bus` value sampled at the last high-strobe edge.
- R3: `addr_lo` stays unchanged while the strobe stays low or stays high, whatever `ad_bus` does. This holds the address through the data phase.
- R4: A rising address strobe, and a strobe held high, leave `addr_lo` unchanged. Only the falling strobe loads it.
- R5: Take the first clock edge that samples `e_clk` low after an edge that sampled it high, with `rd_wr_n` low at that high edge. At the next edge, `wr_data` loads the `ad_bus` value sampled at that last high-E edge, and `wr_valid` goes high.
- R6: `wr_valid` is high for exactly one clock cycle per write.
- R7: A falling E with `rd_wr_n` high (a read) leaves `wr_data` unchanged and keeps `wr_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_bus | input | BUS_W | Shared address/data pins |
| addr_strobe | input | 1 | High while the pins carry the low address |
| e_clk | input | 1 | Bus phase clock; high during the data phase |
| rd_wr_n | input | 1 | 1 = read cycle, 0 = write cycle |
| addr_lo | output | BUS_W | Held low address byte |
| wr_data | output | BUS_W | Byte taken on the last write |
| wr_valid | output | 1 | One-cycle pulse when `wr_data` is refreshed |

## Verification
The bench runs full write and read bus cycles with distinct address and data bytes. A read that follows a write shows that the data register ignores reads. The pins keep changing during the strobe-low and strobe-high windows, which separates a design that holds the address from one that follows the bus. A rising strobe held over several cycles with a new byte separates rising-edge capture from falling-edge capture. Back-to-back writes and an E pulse held long show whether the valid pulse is one cycle wide and in the right cycle.

// File: rtl/adbus_pkg.sv
// Shared types for the address/data bus splitter.
// Assumes all bus control inputs are sampled on one system clock.
package adbus_pkg;
    // Sampled bus control lines
    typedef struct packed {
        logic strobe;   // address strobe
        logic ephase;   // E phase
        logic rdwr;     // 1 = read, 0 = write
    } ctrl_t;

    localparam int CTRL_W = 3;
endpackage

// File: rtl/adbus_sampler.sv
// Two-stage sample register for the shared bus and its control lines.
// Stage "cur" holds the latest sample and stage "prev" the one before.
// Assumes inputs are stable around the sampling edge.
module adbus_sampler
    import adbus_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_in,
    input  ctrl_t            ctrl_in,
    output logic [BUS_W-1:0] bus_cur,
    output logic [BUS_W-1:0] bus_prev,
    output ctrl_t            ctrl_cur,
    output ctrl_t            ctrl_prev
);
    // Shift the sampled bus and controls down two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_cur   <= '0;
            bus_prev  <= '0;
            ctrl_cur  <= '0;
            ctrl_prev <= '0;
        end else begin
            bus_cur   <= bus_in;
            bus_prev  <= bus_cur;
            ctrl_cur  <= ctrl_in;
            ctrl_prev <= ctrl_cur;
        end
    end
endmodule

// File: rtl/adbus_fall_detect.sv
// Per-bit falling-edge detector on two consecutive samples.
// Assumes prev is the sample taken one clock before cur.
module adbus_fall_detect #(
    parameter int N = 2
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // High then low marks a falling edge
        assign fall[i] = prev[i] & ~cur[i];
    end
endmodule

// File: rtl/adbus_addr_hold.sv
// Low-address holding register: loads on a strobe fall, holds otherwise.
// Assumes load_val is the bus sample taken while the strobe was high.
module adbus_addr_hold #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] load_val,
    output logic [BUS_W-1:0] addr_q
);
    // Capture the address on the strobe fall only
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= load_val;
    end
endmodule

// File: rtl/adbus_wr_grab.sv
// Write data capture: on an E fall during a write, takes the byte and pulses valid.
// Assumes is_read and byte_in are aligned with the last E-high sample.
module adbus_wr_grab #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             e_fall,
    input  logic             is_read,
    input  logic [BUS_W-1:0] byte_in,
    output logic [BUS_W-1:0] data_q,
    output logic             valid_q
);
    logic take;
    // A write ends at the E fall when read/write was low
    assign take = e_fall & ~is_read;

    // Hold the written byte and raise a one-cycle valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) data_q <= byte_in;
        end
    end
endmodule

// File: rtl/adbus_demux.sv
// Top of the multiplexed address/data bus splitter.
// Samples the shared pins and controls. Holds the low address from the
// strobe fall on, and takes write data at the fall of E.
// Assumes a synchronous, active-low reset and one clock domain.
module adbus_demux
    import adbus_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] ad_bus,
    input  logic             addr_strobe,
    input  logic             e_clk,
    input  logic             rd_wr_n,
    output logic [BUS_W-1:0] addr_lo,
    output logic [BUS_W-1:0] wr_data,
    output logic             wr_valid
);
    localparam int EDGE_N = 2;

    ctrl_t            ctrl_in, ctrl_cur, ctrl_prev;
    logic [BUS_W-1:0] bus_cur, bus_prev;
    logic [EDGE_N-1:0] edge_cur, edge_prev, edge_fall;
    logic             as_fall, e_fall;

    // Bundle the raw control lines
    assign ctrl_in = '{strobe: addr_strobe, ephase: e_clk, rdwr: rd_wr_n};

    adbus_sampler #(.BUS_W(BUS_W)) u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (ad_bus),
        .ctrl_in  (ctrl_in),
        .bus_cur  (bus_cur),
        .bus_prev (bus_prev),
        .ctrl_cur (ctrl_cur),
        .ctrl_prev(ctrl_prev)
    );

    // Bit 0 = strobe, bit 1 = E phase
    assign edge_cur  = {ctrl_cur.ephase,  ctrl_cur.strobe};
    assign edge_prev = {ctrl_prev.ephase, ctrl_prev.strobe};

    adbus_fall_detect #(.N(EDGE_N)) u_fall (
        .cur (edge_cur),
        .prev(edge_prev),
        .fall(edge_fall)
    );

    assign as_fall = edge_fall[0];
    assign e_fall  = edge_fall[1];

    adbus_addr_hold #(.BUS_W(BUS_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (as_fall),
        .load_val(bus_prev),
        .addr_q  (addr_lo)
    );

    adbus_wr_grab #(.BUS_W(BUS_W)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .e_fall (e_fall),
        .is_read(ctrl_prev.rdwr),
        .byte_in(bus_prev),
        .data_q (wr_data),
        .valid_q(wr_valid)
    );
endmodule

// File: rtl/adbus_demux_chk.sv
// Assertion checker for adbus_demux, bound to every instance of the top.
module adbus_demux_chk #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] addr_lo,
    input logic [BUS_W-1:0] wr_data,
    input logic             wr_valid,
    input logic             as_fall,
    input logic             e_fall
);
    // Reset clears outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (addr_lo == '0 && wr_data == '0 && !wr_valid));

    // Address moves only after a strobe fall
    assert_addr_only_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_lo) |-> $past(as_fall));

    // Valid comes only after an E fall
    assert_valid_after_efall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(e_fall));

    // Valid is a single-cycle pulse
    assert_valid_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // Data changes only together with valid
    assert_data_moves_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_data) |-> wr_valid);
endmodule

bind adbus_demux adbus_demux_chk #(.BUS_W(BUS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_lo (addr_lo),
    .wr_data (wr_data),
    .wr_valid(wr_valid),
    .as_fall (as_fall),
    .e_fall  (e_fall)
);

// File: tb/adbus_demux_tb.sv
module adbus_demux_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_W      = 8;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [BUS_W-1:0] ad_bus = '0;
    logic             addr_strobe = 1'b0;
    logic             e_clk = 1'b0;
    logic             rd_wr_n = 1'b1;
    logic [BUS_W-1:0] addr_lo, wr_data;
    logic             wr_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int valid_seen = 0;
    string phase_tag = "R1";

    // Reference model state
    typedef struct {
        bit       as_v;
        bit       e_v;
        bit       rw_v;
        bit [7:0] bus_v;
    } smp_t;
    smp_t hist[$];
    bit [7:0] m_addr = 0;
    bit [7:0] m_data = 0;
    bit       m_valid = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adbus_demux #(.BUS_W(BUS_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ad_bus     (ad_bus),
        .addr_strobe(addr_strobe),
        .e_clk      (e_clk),
        .rd_wr_n    (rd_wr_n),
        .addr_lo    (addr_lo),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid)
    );

    // Behavioural model updated at each edge from the inputs seen so far
    always @(posedge clk) begin
        smp_t s, o, n;
        s.as_v = addr_strobe; s.e_v = e_clk; s.rw_v = rd_wr_n; s.bus_v = ad_bus;
        if (!rst_n) begin
            m_addr = 0; m_data = 0; m_valid = 0;
            hist = {};
            o.as_v = 0; o.e_v = 0; o.rw_v = 0; o.bus_v = 0;
            hist.push_back(o); hist.push_back(o);
        end else begin
            o = hist[0]; n = hist[1];
            if (o.as_v && !n.as_v) m_addr = o.bus_v;
            m_valid = 0;
            if (o.e_v && !n.e_v && !o.rw_v) begin
                m_data = o.bus_v; m_valid = 1;
            end
            void'(hist.pop_front());
            hist.push_back(s);
        end
    end

    // Compare the outputs with the model on every falling edge
    always @(negedge clk) begin
        cycles++;
        if (wr_valid) valid_seen++;
        checks++;
        if (addr_lo !== m_addr || wr_data !== m_data || wr_valid !== m_valid) begin
            errors++;
            $display("FAIL %s cycle %0d: addr=%h data=%h valid=%b expected addr=%h data=%h valid=%b",
                     phase_tag, cycles, addr_lo, wr_data, wr_valid, m_addr, m_data, m_valid);
        end
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One full bus cycle: address phase, then data phase under E
    task automatic bus_cycle(logic [7:0] a, logic [7:0] d, logic rd);
        ad_bus = a; addr_strobe = 1; rd_wr_n = rd;
        tick(2);
        addr_strobe = 0; ad_bus = 8'h5A;
        tick(1);
        ad_bus = d; e_clk = 1;
        tick(3);
        e_clk = 0; ad_bus = 8'hC3;
        tick(3);
    endtask

    initial begin
        tick(3);
        phase_tag = "R1";
        expect8("R1 addr after reset", addr_lo, 8'h00);
        expect8("R1 data after reset", wr_data, 8'h00);
        expect_int("R1 valid after reset", wr_valid, 0);
        rst_n = 1;
        tick(2);

        phase_tag = "R5";
        valid_seen = 0;
        bus_cycle(8'h3C, 8'hA7, 1'b0);
        expect8("R2 address held after write", addr_lo, 8'h3C);
        expect8("R5 write data", wr_data, 8'hA7);
        expect_int("R6 valid pulse width", valid_seen, 1);

        phase_tag = "R7";
        valid_seen = 0;
        bus_cycle(8'hE1, 8'h19, 1'b1);
        expect8("R2 address after read", addr_lo, 8'hE1);
        expect8("R7 data unchanged by read", wr_data, 8'hA7);
        expect_int("R7 no valid on read", valid_seen, 0);

        phase_tag = "R3";
        for (int i = 0; i < 6; i++) begin
            ad_bus = 8'(i * 37 + 5);
            tick(1);
        end
        expect8("R3 address ignores bus while strobe low", addr_lo, 8'hE1);

        phase_tag = "R4";
        ad_bus = 8'h77; addr_strobe = 1;
        tick(4);
        expect8("R4 rising strobe no load", addr_lo, 8'hE1);
        ad_bus = 8'h66;
        tick(1);
        expect8("R3 address ignores bus while strobe high", addr_lo, 8'hE1);
        addr_strobe = 0;
        tick(3);
        expect8("R2 load value from last high sample", addr_lo, 8'h66);

        phase_tag = "R6";
        valid_seen = 0;
        bus_cycle(8'h10, 8'h01, 1'b0);
        bus_cycle(8'h20, 8'hFE, 1'b0);
        expect_int("R6 two writes two pulses", valid_seen, 2);
        expect8("R5 second write data", wr_data, 8'hFE);
        expect8("R2 second address", addr_lo, 8'h20);

        phase_tag = "R1";
        rst_n = 0;
        tick(2);
        expect8("R1 addr cleared mid-run", addr_lo, 8'h00);
        expect8("R1 data cleared mid-run", wr_data, 8'h00);
        rst_n = 1;
        tick(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule